// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point conditional instruction (branch, set-on-condition, decrement-and-branch or conditional trap) finds its condition true. It takes the predicate field of the instruction together with the negative, zero and not-a-number condition bits of the floating-point status. One clock later it returns a valid strobe with the verdict. It also flags a predicate code that does not exist and returns the updated exception byte. From that byte and the exception-enable mask it works out whether a trap must be taken instead of acting on the condition.

The 32 legal predicate codes reduce to eight base relations. One predicate bit inverts the relation. Another bit marks the test as one that is not aware of unordered operands. Such a test raises the unordered-condition exception when the NaN condition bit is set. The surrounding pipeline uses `resTaken` to steer the branch, set or decrement logic and uses `resTrap` to divert to the exception path. It computes no displacement and updates no program counter.

Top module: `fpcc_eval`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `resValid`, `resTrue`, `resIllegal`, `resTrap`, `resTaken` and `excOut` are all 0.
- R2: `resValid` is high exactly in the cycle after a cycle with `evalValid` high. The other outputs in that cycle describe the inputs sampled with that `evalValid`.
- R3: Only `predWord[5:0]` affects the result. Bits above bit 5 have no effect on any output.
- R4: A predicate with bit 5 set is illegal. It gives `resIllegal`=1, `resTrue`=0, `resTrap`=0 and `resTaken`=0, and `excOut` is `excIn` unchanged.
- R5: For a legal predicate with bit 3 clear, the base relation is `predWord[2:0]` and `resTrue` is its value. The relations are: 0 never; 1 zero (Z); 2 greater (N, Z and NaN all clear); 3 greater-or-equal (Z, or both N and NaN clear); 4 less (N set, Z and NaN clear); 5 less-or-equal (Z, or N set with NaN clear); 6 greater-or-less (Z and NaN clear); 7 ordered (NaN clear).
- R6: For a legal predicate with bit 3 set, the base relation is the inverse of `predWord[2:0]` (the low four bits XOR 0xF), and `resTrue` is the complement of that relation.
- R7: For a legal predicate, `excOut` bit 7 (the unordered-condition bit) is 1 exactly when `predWord[4]` is 1 and `ccNan` is 1.
- R8: For a legal predicate, every `excOut` bit other than bit 7 is 0, whatever `excIn` holds.
- R9: For a legal predicate, `resTrap` is 1 exactly when `excOut & excEnable` is nonzero. `resTaken` equals `resTrue & ~resTrap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evalValid | input | 1 | Evaluate the inputs in this cycle |
| predWord | input | PRED_W (16) | Instruction word carrying the predicate in bits 5:0 |
| ccNeg | input | 1 | Negative condition bit |
| ccZero | input | 1 | Zero condition bit |
| ccNan | input | 1 | Not-a-number condition bit |
| excIn | input | EXC_W (8) | Current exception byte |
| excEnable | input | EXC_W (8) | Exception enable mask, same bit layout as excIn |
| resValid | output | 1 | Result strobe, one cycle after evalValid |
| resTrue | output | 1 | Condition verdict |
| resIllegal | output | 1 | Predicate code does not exist |
| resTrap | output | 1 | Enabled exception pending, trap instead of acting |
| resTaken | output | 1 | Condition true and no trap |
| excOut | output | EXC_W (8) | Updated exception byte |

## Verification
Two functions can land in the same cycle: raising the unordered exception and acting on a true condition. When an IEEE-unaware predicate whose relation is true meets a set NaN bit while the unordered enable is on, the trap must win over the verdict. `resTrue` then stays high, and `resTaken` drops. The bench provokes this by sweeping every 6-bit predicate against all eight condition-bit patterns under several random enable masks. Its scoreboard judges each result against a model built from the relation table, so the trap, taken and exception fields are compared together for the same item.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  typedef enum logic [2:0] {
    REL_NEVER = 3'd0,
    REL_EQ    = 3'd1,
    REL_GT    = 3'd2,
    REL_GE    = 3'd3,
    REL_LT    = 3'd4,
    REL_LE    = 3'd5,
    REL_GL    = 3'd6,
    REL_ORD   = 3'd7
  } baseRel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     illegal;
    logic     nonAware;
    logic     invert;
    baseRel_t baseRel;
  } evalStrobe_t;

  function automatic logic relHolds(baseRel_t rel, logic neg, logic zero, logic nan);
    logic r;
    unique case (rel)
      REL_NEVER: r = 1'b0;
      REL_EQ:    r = zero;
      REL_GT:    r = ~(nan | zero | neg);
      REL_GE:    r = zero | ~(nan | neg);
      REL_LT:    r = neg & ~nan & ~zero;
      REL_LE:    r = zero | (neg & ~nan);
      REL_GL:    r = ~(nan | zero);
      REL_ORD:   r = ~nan;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpcc_ctrl.sv
module fpcc_ctrl
  import fpcc_pkg::*;
#(
  parameter int PRED_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evalValid,
  input  logic [PRED_W-1:0] predWord,
  output evalStrobe_t       strobe,
  output logic              resValid
);

  localparam int PRED_KEEP = 6;

  logic [PRED_KEEP-1:0] pred;
  assign pred = predWord[PRED_KEEP-1:0];

  generate
    if (PRED_W > PRED_KEEP) begin : g_hiBits
      logic unusedPredHi;
      assign unusedPredHi = ^predWord[PRED_W-1:PRED_KEEP];
    end
  endgenerate

  always_comb begin
    strobe.load     = evalValid;
    strobe.illegal  = pred[5];
    strobe.nonAware = pred[4];
    strobe.invert   = pred[3];
    strobe.baseRel  = baseRel_t'(pred[3] ? ~pred[2:0] : pred[2:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resValid <= 1'b0;
    else        resValid <= evalValid;
  end

endmodule

// File: rtl/fpcc_datapath.sv
module fpcc_datapath
  import fpcc_pkg::*;
#(
  parameter int EXC_W     = 8,
  parameter int UNORD_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  evalStrobe_t      strobe,
  input  logic             ccNeg,
  input  logic             ccZero,
  input  logic             ccNan,
  input  logic [EXC_W-1:0] excIn,
  input  logic [EXC_W-1:0] excEnable,
  output logic             resTrue,
  output logic             resIllegal,
  output logic             resTrap,
  output logic             resTaken,
  output logic [EXC_W-1:0] excOut
);

  logic             relNow;
  logic             truthNext;
  logic             trapNext;
  logic [EXC_W-1:0] excNext;

  always_comb begin
    relNow  = relHolds(strobe.baseRel, ccNeg, ccZero, ccNan);
    excNext = '0;
    excNext[UNORD_BIT] = strobe.nonAware & ccNan;
    if (strobe.illegal) begin
      truthNext = 1'b0;
      excNext   = excIn;
      trapNext  = 1'b0;
    end else begin
      truthNext = relNow ^ strobe.invert;
      trapNext  = |(excNext & excEnable);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resTrue    <= 1'b0;
      resIllegal <= 1'b0;
      resTrap    <= 1'b0;
      resTaken   <= 1'b0;
      excOut     <= '0;
    end else if (strobe.load) begin
      resTrue    <= truthNext;
      resIllegal <= strobe.illegal;
      resTrap    <= trapNext;
      resTaken   <= truthNext & ~trapNext;
      excOut     <= excNext;
    end
  end

endmodule

// File: rtl/fpcc_eval.sv
module fpcc_eval
  import fpcc_pkg::*;
#(
  parameter int PRED_W    = 16,
  parameter int EXC_W     = 8,
  parameter int UNORD_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evalValid,
  input  logic [PRED_W-1:0] predWord,
  input  logic              ccNeg,
  input  logic              ccZero,
  input  logic              ccNan,
  input  logic [EXC_W-1:0]  excIn,
  input  logic [EXC_W-1:0]  excEnable,
  output logic              resValid,
  output logic              resTrue,
  output logic              resIllegal,
  output logic              resTrap,
  output logic              resTaken,
  output logic [EXC_W-1:0]  excOut
);

  evalStrobe_t strobe;

  fpcc_ctrl #(.PRED_W(PRED_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .evalValid(evalValid),
    .predWord (predWord),
    .strobe   (strobe),
    .resValid (resValid)
  );

  fpcc_datapath #(.EXC_W(EXC_W), .UNORD_BIT(UNORD_BIT)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .ccNeg     (ccNeg),
    .ccZero    (ccZero),
    .ccNan     (ccNan),
    .excIn     (excIn),
    .excEnable (excEnable),
    .resTrue   (resTrue),
    .resIllegal(resIllegal),
    .resTrap   (resTrap),
    .resTaken  (resTaken),
    .excOut    (excOut)
  );

endmodule

// File: rtl/fpcc_eval_chk.sv
module fpcc_eval_chk #(
  parameter int PRED_W    = 16,
  parameter int EXC_W     = 8,
  parameter int UNORD_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evalValid,
  input logic [PRED_W-1:0] predWord,
  input logic              ccNan,
  input logic [EXC_W-1:0]  excIn,
  input logic              resValid,
  input logic              resTrue,
  input logic              resIllegal,
  input logic              resTrap,
  input logic              resTaken,
  input logic [EXC_W-1:0]  excOut
);

  logic [EXC_W-1:0] otherMask;
  always_comb begin
    otherMask = '1;
    otherMask[UNORD_BIT] = 1'b0;
  end

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evalValid |=> resValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evalValid |=> !resValid);

  // R4
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resIllegal |-> (!resTrue && !resTrap && !resTaken));

  // R4
  illegal_exc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evalValid && predWord[5] |=> excOut == $past(excIn));

  // R7
  unord_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evalValid && !predWord[5] |=> excOut[UNORD_BIT] == $past(predWord[4] && ccNan));

  // R8
  exc_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && !resIllegal |-> (excOut & otherMask) == '0);

  // R9
  taken_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resTaken |-> (resTrue && !resTrap));

endmodule

bind fpcc_eval fpcc_eval_chk #(.PRED_W(PRED_W), .EXC_W(EXC_W), .UNORD_BIT(UNORD_BIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evalValid (evalValid),
  .predWord  (predWord),
  .ccNan     (ccNan),
  .excIn     (excIn),
  .resValid  (resValid),
  .resTrue   (resTrue),
  .resIllegal(resIllegal),
  .resTrap   (resTrap),
  .resTaken  (resTaken),
  .excOut    (excOut)
);

// File: tb/test_fpcc_eval.sv
module test_fpcc_eval;

  localparam int PRED_W = 16;
  localparam int EXC_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              evalValid = 1'b0;
  logic [PRED_W-1:0] predWord = '0;
  logic              ccNeg = 1'b0, ccZero = 1'b0, ccNan = 1'b0;
  logic [EXC_W-1:0]  excIn = '0, excEnable = '0;
  logic              resValid, resTrue, resIllegal, resTrap, resTaken;
  logic [EXC_W-1:0]  excOut;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  typedef struct {
    logic [5:0]       pred;
    bit               hiSet;
    logic             isTrue;
    logic             illegal;
    logic             trap;
    logic             taken;
    logic [EXC_W-1:0] exc;
  } expItem_t;

  expItem_t scoreQ[$];

  always #5 clk = ~clk;

  fpcc_eval #(.PRED_W(PRED_W), .EXC_W(EXC_W), .UNORD_BIT(7)) i_fpcc_eval (
    .clk(clk), .rst_n(rst_n), .evalValid(evalValid), .predWord(predWord),
    .ccNeg(ccNeg), .ccZero(ccZero), .ccNan(ccNan), .excIn(excIn),
    .excEnable(excEnable), .resValid(resValid), .resTrue(resTrue),
    .resIllegal(resIllegal), .resTrap(resTrap), .resTaken(resTaken),
    .excOut(excOut)
  );

  function automatic logic baseValue(logic [2:0] b, logic n, logic z, logic q);
    case (b)
      3'd0: return 1'b0;
      3'd1: return z;
      3'd2: return !q && !z && !n;
      3'd3: return z || (!q && !n);
      3'd4: return n && !q && !z;
      3'd5: return z || (n && !q);
      3'd6: return !q && !z;
      default: return !q;
    endcase
  endfunction

  function automatic expItem_t model(logic [PRED_W-1:0] w, logic n, logic z, logic q,
                                     logic [EXC_W-1:0] ei, logic [EXC_W-1:0] en);
    expItem_t e;
    logic [3:0] low;
    e.pred  = w[5:0];
    e.hiSet = (w[PRED_W-1:6] != '0);
    if (w[5]) begin
      e.illegal = 1; e.isTrue = 0; e.trap = 0; e.taken = 0; e.exc = ei;
    end else begin
      low = w[3:0];
      if (w[3]) low = low ^ 4'hF;
      e.illegal = 0;
      e.isTrue  = baseValue(low[2:0], n, z, q) ^ w[3];
      e.exc     = '0;
      e.exc[7]  = w[4] && q;
      e.trap    = (e.exc & en) != '0;
      e.taken   = e.isTrue && !e.trap;
    end
    return e;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [PRED_W-1:0] w, logic n, logic z, logic q,
                       logic [EXC_W-1:0] ei, logic [EXC_W-1:0] en);
    @(negedge clk);
    evalValid = 1; predWord = w; ccNeg = n; ccZero = z; ccNan = q;
    excIn = ei; excEnable = en;
    scoreQ.push_back(model(w, n, z, q, ei, en));
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      evalValid = 0;
      predWord = PRED_W'($urandom);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && resValid) begin
      if (scoreQ.size() == 0) begin
        chk(0, "R2", "unexpected resValid", 1, 0);
      end else begin
        expItem_t e;
        string tTag;
        e = scoreQ.pop_front();
        tTag = e.illegal ? "R4" : (e.pred[3] ? "R6" : "R5");
        if (e.hiSet) tTag = {tTag, "/R3"};
        chk(resIllegal == e.illegal, "R4", "resIllegal", resIllegal, e.illegal);
        chk(resTrue == e.isTrue, tTag, $sformatf("resTrue pred=%0h", e.pred), resTrue, e.isTrue);
        chk(excOut[7] == e.exc[7], e.illegal ? "R4" : "R7", "excOut[7]", excOut, e.exc);
        chk(excOut[6:0] == e.exc[6:0], e.illegal ? "R4" : "R8", "excOut[6:0]", excOut, e.exc);
        chk(resTrap == e.trap && resTaken == e.taken, e.illegal ? "R4" : "R9",
            "trap,taken", {resTrap, resTaken}, {e.trap, e.taken});
      end
    end
  end

  initial begin
    // R1: outputs quiet in reset
    repeat (3) @(negedge clk);
    chk({resValid, resTrue, resIllegal, resTrap, resTaken, excOut} == '0, "R1",
        "reset outputs", {resValid, resTrue, resIllegal, resTrap, resTaken, excOut}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({resValid, resTrue, resIllegal, resTrap, resTaken, excOut} == '0, "R1",
        "after reset", {resValid, resTrue, resIllegal, resTrap, resTaken, excOut}, 0);

    // full sweep, back to back, upper bits clear
    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p < 64; p++) begin
        for (int c = 0; c < 8; c++) begin
          logic [EXC_W-1:0] en;
          en = (m == 0) ? 8'h00 : (m == 1) ? 8'h80 : 8'($urandom) | 8'h80;
          drive(PRED_W'(p), c[2], c[1], c[0], 8'($urandom), en);
        end
      end
    end

    // R3: junk in upper predicate word bits, with gaps between evaluations
    for (int k = 0; k < 200; k++) begin
      logic [PRED_W-1:0] w;
      w = PRED_W'($urandom);
      w[PRED_W-1] = 1'b1;
      drive(w, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
      if (k % 3 == 0) idle(1 + (k % 4));
    end

    // R9: unordered raise together with a true verdict, enabled vs disabled
    drive(16'h001F, 0, 0, 1, 8'hFF, 8'h80);  // not-false, nonaware, NaN: trap
    drive(16'h001F, 0, 0, 1, 8'hFF, 8'h7F);  // same, unordered disabled: taken
    drive(16'h000F, 0, 0, 1, 8'hFF, 8'hFF);  // aware twin: no raise

    idle(4);
    // R2: every pushed item consumed
    chk(scoreQ.size() == 0, "R2", "items left", scoreQ.size(), 0);
    chk(resValid == 0, "R2", "resValid idle", resValid, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule